// File: doc/BRIEF.md
# Device Interrupt Pin Routing Registers

This block holds the interrupt pin routing words for the on-chip device slots numbered 25 through 31. Each routing word assigns that slot's four interrupt pins (INTA, INTB, INTC, INTD) to one of eight shared interrupt lines, numbered 0 to 7 and named A to H. Software reads and writes the words through a simple byte-addressed, little-endian register port. Any other logic can ask a purely combinational lookup port which shared line a given slot and pin drive.

Slot 30 is hard-wired and cannot be reprogrammed. Slots 0 to 24 have no register and follow a fixed rotating default. That default only ever uses lines E to H, so lines A to D stay free for other use.

The register port takes a length of one to four bytes. The address is folded into the 32-byte region. An access that would run past the end of the region is shortened, and it never wraps to the start. Every accepted write pulses a routing-changed output, so that consumers holding a copy of the routing can refresh it.

Top module: `rtr_pin_router`

## Requirements
- R1: A routing word holds four 4-bit fields: INTA in bits [3:0], INTB in [7:4], INTC in [11:8] and INTD in [15:12]. The lookup returns the low 3 bits of the addressed field, so field values 8 to 15 alias to 0 to 7.
- R2: The routing word of slot s (25 to 31) sits at byte offset 2*(s-25), low byte first. A 32-bit general control word sits at offsets 16 to 19, low byte first. Offsets 14, 15 and 20 to 31 are plain read/write bytes.
- R3: Slot 30's word, at offsets 10 and 11, always reads 16'h7654, and writes to it are dropped. A lookup of slot 30 returns pin + 4, so INTA to INTD map to lines E to H.
- R4: A lookup of any slot from 0 to 24 returns ((slot + pin) mod 4) + 4.
- R5: After a synchronous reset (rst_n low at a clock edge), each programmable slot word equals DEFAULT_ROUTE (16'h3210), the control word equals CTRL_DEFAULT (32'h0000_0001), every other byte is zero, and rd_valid and route_chg are low.
- R6: Only the low 5 bits of acc_addr select the byte offset. Higher address bits are ignored.
- R7: An access covers acc_len+1 bytes from the masked offset, cut at offset 31. A write never touches bytes past the cut. On a read, lanes past the cut return zero.
- R8: A read request at a clock edge raises rd_valid for exactly the next cycle. rd_data then holds the covered bytes, with the lowest offset in lane 0 (bits [7:0]).
- R9: route_chg is high for exactly the one cycle after each accepted write, including a write aimed at slot 30, and low otherwise.
- R10: The lookup port shows a written routing word from the cycle right after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address; low 5 bits used |
| acc_len | input | 2 | Access length minus one (1 to 4 bytes) |
| acc_wdata | input | 32 | Write data, lane 0 to the lowest offset |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, uncovered lanes zero |
| route_chg | output | 1 | One-cycle pulse after each write |
| lk_slot | input | 5 | Lookup slot number |
| lk_pin | input | 2 | Lookup pin (0 = INTA to 3 = INTD) |
| lk_line | output | 3 | Shared line number for that slot and pin |

## Verification
A corrupted storage byte shows up in two places: on the read port one cycle after the read request, and on the lookup port in the same cycle as the lookup. The bench therefore keeps its own byte image of the region and compares both ports against it after every write. A mistake in the clipping length or the write mask shows up as a changed byte at offset 0 or in slot 30's word, or as a nonzero lane past the cut. Reads placed right after the clipped and masked writes catch it in the next cycle. A broken notification shows up at route_chg in the cycle after the write.

// File: rtl/rtr_pkg.sv
// Shared constants and helpers for the pin routing register block.
// Assumes a 32-byte region, seven programmable slots starting at 25,
// and one hard-wired slot inside that range.
package rtr_pkg;
    localparam int PINS         = 4;
    localparam int FIELD_W      = 4;
    localparam int LINE_W       = 3;
    localparam int SLOT_W       = 5;
    localparam int WORD_W       = PINS * FIELD_W;
    localparam int FIRST_PROG   = 25;
    localparam int NUM_PROG     = 7;
    localparam int FIXED_SLOT   = 30;
    localparam int REGION_BYTES = 32;
    localparam int OFS_W        = $clog2(REGION_BYTES);
    localparam int CTRL_OFS     = 16;
    localparam int CTRL_BYTES   = 4;
    localparam int DATA_BYTES   = 4;
    localparam int LEN_W        = $clog2(DATA_BYTES);
    localparam int IDX_W        = $clog2(NUM_PROG);

    // Routing word of the hard-wired slot: pin p drives line p + 4.
    function automatic logic [WORD_W-1:0] fixed_word();
        logic [WORD_W-1:0] w;
        w = '0;
        for (int p = 0; p < PINS; p++) begin
            w[p*FIELD_W +: FIELD_W] = FIELD_W'(p + 4);
        end
        return w;
    endfunction
endpackage

// File: rtl/rtr_regfile.sv
// Byte-addressed storage for the routing words and the control word.
// Clips every access at the region end, protects the hard-wired slot's
// bytes, returns registered read data and a write notification pulse.
// Assumes a single requester with no back-pressure.
module rtr_regfile
    import rtr_pkg::*;
#(
    parameter int                ADDR_W        = 8,
    parameter logic [WORD_W-1:0] DEFAULT_ROUTE = 16'h3210,
    parameter logic [31:0]       CTRL_DEFAULT  = 32'h0000_0001
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_valid,
    input  logic                       acc_write,
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic [LEN_W-1:0]           acc_len,
    input  logic [DATA_BYTES*8-1:0]    acc_wdata,
    output logic                       rd_valid,
    output logic [DATA_BYTES*8-1:0]    rd_data,
    output logic                       route_chg,
    output logic [NUM_PROG*WORD_W-1:0] slot_words
);
    localparam int FIXED_IDX = FIXED_SLOT - FIRST_PROG;

    // Reset value of one byte of the region.
    function automatic logic [7:0] reset_byte(int idx);
        logic [WORD_W-1:0] w;
        if (idx < 2 * NUM_PROG) begin
            w = (idx / 2 == FIXED_IDX) ? fixed_word() : DEFAULT_ROUTE;
            return w[(idx % 2)*8 +: 8];
        end
        if (idx >= CTRL_OFS && idx < CTRL_OFS + CTRL_BYTES) begin
            return CTRL_DEFAULT[(idx - CTRL_OFS)*8 +: 8];
        end
        return 8'h00;
    endfunction

    // True for the bytes that software cannot change.
    function automatic logic byte_ro(int idx);
        return (idx < 2 * NUM_PROG) && (idx / 2 == FIXED_IDX);
    endfunction

    logic [7:0]       mem [REGION_BYTES];
    logic [OFS_W-1:0] base;
    logic [OFS_W:0]   room, want, eff;
    logic             lane_on  [DATA_BYTES];
    logic [OFS_W-1:0] lane_ofs [DATA_BYTES];
    logic             wr_hit   [REGION_BYTES];
    logic [7:0]       wr_byte  [REGION_BYTES];
    logic [DATA_BYTES*8-1:0] rd_next;
    logic             do_wr, do_rd;

    assign do_wr = acc_valid &&  acc_write;
    assign do_rd = acc_valid && !acc_write;
    assign base  = acc_addr[OFS_W-1:0];

    // Clip the requested length to the bytes left before the region end.
    always_comb begin
        room = (OFS_W+1)'(REGION_BYTES) - {1'b0, base};
        want = (OFS_W+1)'(acc_len) + (OFS_W+1)'(1);
        eff  = (want > room) ? room : want;
        for (int k = 0; k < DATA_BYTES; k++) begin
            lane_on[k]  = (OFS_W+1)'(k) < eff;
            lane_ofs[k] = base + OFS_W'(k);
        end
    end

    // Steer write lanes onto region bytes.
    always_comb begin
        for (int b = 0; b < REGION_BYTES; b++) begin
            wr_hit[b]  = 1'b0;
            wr_byte[b] = 8'h00;
            for (int k = 0; k < DATA_BYTES; k++) begin
                if (do_wr && lane_on[k] && lane_ofs[k] == OFS_W'(b)) begin
                    wr_hit[b]  = 1'b1;
                    wr_byte[b] = acc_wdata[k*8 +: 8];
                end
            end
        end
    end

    // Region storage: reload defaults on reset, accept unprotected writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < REGION_BYTES; b++) begin
                mem[b] <= reset_byte(b);
            end
        end else begin
            for (int b = 0; b < REGION_BYTES; b++) begin
                if (wr_hit[b] && !byte_ro(b)) begin
                    mem[b] <= wr_byte[b];
                end
            end
        end
    end

    // Gather read lanes, zero where the clipped access does not reach.
    always_comb begin
        for (int k = 0; k < DATA_BYTES; k++) begin
            rd_next[k*8 +: 8] = lane_on[k] ? mem[lane_ofs[k]] : 8'h00;
        end
    end

    // Register the read response and the write notification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            route_chg <= 1'b0;
        end else begin
            rd_valid  <= do_rd;
            route_chg <= do_wr;
            if (do_rd) begin
                rd_data <= rd_next;
            end
        end
    end

    for (genvar i = 0; i < NUM_PROG; i++) begin : g_word
        assign slot_words[i*WORD_W +: WORD_W] = {mem[2*i+1], mem[2*i]};
    end
endmodule

// File: rtl/rtr_lookup.sv
// Combinational slot/pin to shared-line lookup.
// Assumes slot_words carries the live programmable routing words;
// the hard-wired slot and slots below the programmable range are fixed.
module rtr_lookup
    import rtr_pkg::*;
(
    input  logic [NUM_PROG*WORD_W-1:0] slot_words,
    input  logic [SLOT_W-1:0]          lk_slot,
    input  logic [1:0]                 lk_pin,
    output logic [LINE_W-1:0]          lk_line
);
    logic [LINE_W-1:0] prog_line [NUM_PROG];
    logic [SLOT_W-1:0] rel;
    logic              in_prog;

    for (genvar i = 0; i < NUM_PROG; i++) begin : g_field
        assign prog_line[i] = slot_words[i*WORD_W + 32'(lk_pin)*FIELD_W +: LINE_W];
    end

    assign rel     = lk_slot - SLOT_W'(FIRST_PROG);
    assign in_prog = (lk_slot >= SLOT_W'(FIRST_PROG)) &&
                     (32'(lk_slot) < FIRST_PROG + NUM_PROG);

    // Pick fixed, programmed or rotating default route.
    always_comb begin
        if (lk_slot == SLOT_W'(FIXED_SLOT)) begin
            lk_line = {1'b1, lk_pin};
        end else if (in_prog) begin
            lk_line = prog_line[rel[IDX_W-1:0]];
        end else begin
            lk_line = {1'b1, lk_slot[1:0] + lk_pin};
        end
    end
endmodule

// File: rtl/rtr_pin_router.sv
// Top of the device interrupt pin routing registers: a register file
// plus a combinational lookup. Assumes one register requester.
module rtr_pin_router
    import rtr_pkg::*;
#(
    parameter int                ADDR_W        = 8,
    parameter logic [WORD_W-1:0] DEFAULT_ROUTE = 16'h3210,
    parameter logic [31:0]       CTRL_DEFAULT  = 32'h0000_0001
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic                    acc_write,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LEN_W-1:0]        acc_len,
    input  logic [DATA_BYTES*8-1:0] acc_wdata,
    output logic                    rd_valid,
    output logic [DATA_BYTES*8-1:0] rd_data,
    output logic                    route_chg,
    input  logic [SLOT_W-1:0]       lk_slot,
    input  logic [1:0]              lk_pin,
    output logic [LINE_W-1:0]       lk_line
);
    logic [NUM_PROG*WORD_W-1:0] slot_words;

    rtr_regfile #(
        .ADDR_W(ADDR_W), .DEFAULT_ROUTE(DEFAULT_ROUTE), .CTRL_DEFAULT(CTRL_DEFAULT)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_len(acc_len), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .route_chg(route_chg),
        .slot_words(slot_words)
    );

    rtr_lookup i_lookup (
        .slot_words(slot_words), .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_line(lk_line)
    );
endmodule

// File: rtl/rtr_pin_router_chk.sv
// Port-level properties of the pin routing registers, bound to the top.
module rtr_pin_router_chk
    import rtr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_valid,
    input logic                    acc_write,
    input logic [ADDR_W-1:0]       acc_addr,
    input logic [LEN_W-1:0]        acc_len,
    input logic [DATA_BYTES*8-1:0] rd_data,
    input logic                    rd_valid,
    input logic                    route_chg,
    input logic [SLOT_W-1:0]       lk_slot,
    input logic [1:0]              lk_pin,
    input logic [LINE_W-1:0]       lk_line
);
    a_r9_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> route_chg);
    a_r9_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_write) |=> !route_chg);
    a_r8_read_response: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> rd_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> !rd_valid);
    a_r7_clip_last_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_addr[OFS_W-1:0] == OFS_W'(REGION_BYTES-1))
        |=> rd_data[DATA_BYTES*8-1:8] == '0);
    a_r3_fixed_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_len != '0 &&
         acc_addr[OFS_W-1:0] == OFS_W'(2*(FIXED_SLOT-FIRST_PROG)))
        |=> rd_data[WORD_W-1:0] == fixed_word());
    a_r3_fixed_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_slot == SLOT_W'(FIXED_SLOT)) |-> lk_line == {1'b1, lk_pin});
    a_r4_default_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_slot < SLOT_W'(FIRST_PROG)) |-> lk_line[LINE_W-1]);
endmodule

bind rtr_pin_router rtr_pin_router_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_len(acc_len), .rd_data(rd_data), .rd_valid(rd_valid),
    .route_chg(route_chg), .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_line(lk_line)
);

// File: tb/test_rtr_pin_router.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected data, a monitor compares.
module test_rtr_pin_router;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_write;
    logic [7:0]  acc_addr;
    logic [1:0]  acc_len;
    logic [31:0] acc_wdata;
    logic        rd_valid, route_chg;
    logic [31:0] rd_data;
    logic [4:0]  lk_slot;
    logic [1:0]  lk_pin;
    logic [2:0]  lk_line;

    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;
    logic [7:0]  mdl [32];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    rtr_pin_router #(.ADDR_W(8)) i_rtr_pin_router (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_len(acc_len), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .route_chg(route_chg),
        .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_line(lk_line)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R5 image: default routes, fixed slot, control word, zeros elsewhere.
    task automatic model_reset();
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        for (int s = 0; s < 7; s++) begin
            mdl[2*s]   = 8'h10;
            mdl[2*s+1] = 8'h32;
        end
        mdl[10] = 8'h54;
        mdl[11] = 8'h76;
        mdl[16] = 8'h01;
    endtask

    function automatic logic [31:0] exp_read(logic [7:0] addr, logic [1:0] len);
        int b = addr % 32;
        logic [31:0] v = '0;
        for (int k = 0; k <= int'(len); k++) begin
            if (b + k < 32) v[k*8 +: 8] = mdl[b+k];
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_line(int slot, int pin);
        logic [15:0] w;
        if (slot == 30) return 32'(pin + 4);
        if (slot >= 25) begin
            w = {mdl[2*(slot-25)+1], mdl[2*(slot-25)]};
            return 32'((w >> (4*pin)) & 16'h7);
        end
        return 32'(((slot + pin) % 4) + 4);
    endfunction

    task automatic do_write(logic [7:0] addr, logic [1:0] len, logic [31:0] data);
        int b = addr % 32;
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_addr = addr; acc_len = len; acc_wdata = data;
        for (int k = 0; k <= int'(len); k++) begin
            if (b + k < 32 && b + k != 10 && b + k != 11) mdl[b+k] = data[k*8 +: 8];
        end
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
        check("R9 pulse after write", 32'(route_chg), 32'd1);
    endtask

    task automatic do_read(logic [7:0] addr, logic [1:0] len, string tag);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_addr = addr; acc_len = len;
        exp_q.push_back(exp_read(addr, len));
        tag_q.push_back(tag);
        @(negedge clk);
        acc_valid = 0;
    endtask

    task automatic check_lookup(int slot, int pin, string tag);
        lk_slot = 5'(slot);
        lk_pin  = 2'(pin);
        #1;
        check(tag, 32'(lk_line), exp_line(slot, pin));
    endtask

    // Monitor: compare each read response against the queued expectation.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rd_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected read data", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        rst_n = 0; acc_valid = 0; acc_write = 0; acc_addr = 0; acc_len = 0;
        acc_wdata = 0; lk_slot = 0; lk_pin = 0;
        model_reset();
        repeat (3) @(negedge clk);
        check("R5 rd_valid after reset", 32'(rd_valid), 32'd0);
        check("R5 route_chg after reset", 32'(route_chg), 32'd0);
        rst_n = 1;

        for (int a = 0; a < 32; a += 4) do_read(8'(a), 2'd3, "R5 R2 reset image");

        for (int s = 0; s < 32; s++) begin
            for (int p = 0; p < 4; p++) begin
                check_lookup(s, p, s == 30 ? "R3 fixed slot" : (s < 25 ? "R4 default" : "R1 reset route"));
            end
        end

        @(negedge clk);
        check("R9 idle no pulse", 32'(route_chg), 32'd0);

        do_write(8'd0, 2'd1, 32'h0000_FEDC);
        for (int p = 0; p < 4; p++) check_lookup(25, p, "R10 R1 alias next cycle");

        do_write(8'd2, 2'd0, 32'h0000_0057);
        for (int p = 0; p < 4; p++) check_lookup(26, p, "R1 byte write");
        do_read(8'd0, 2'd3, "R2 slot words");

        do_write(8'd10, 2'd1, 32'h0000_FFFF);
        do_read(8'd10, 2'd1, "R3 fixed word read");
        for (int p = 0; p < 4; p++) check_lookup(30, p, "R3 fixed lookup");

        do_write(8'd8, 2'd3, 32'hAAAA_1234);
        do_read(8'd8, 2'd3, "R3 partial protect");
        for (int p = 0; p < 4; p++) check_lookup(29, p, "R1 slot 29");

        do_write(8'd30, 2'd3, 32'hDDCC_BBAA);
        do_read(8'd30, 2'd3, "R7 clipped read");
        do_read(8'd0, 2'd1, "R7 no wrap");
        do_read(8'd31, 2'd2, "R7 last byte");

        do_write(8'h52, 2'd1, 32'h0000_9988);
        do_read(8'd16, 2'd3, "R6 masked write");
        do_read(8'hF0, 2'd3, "R6 masked read");

        do_write(8'd12, 2'd1, 32'h0000_0F70);
        for (int p = 0; p < 4; p++) check_lookup(31, p, "R1 slot 31 alias");

        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1;
        for (int a = 0; a < 32; a += 4) do_read(8'(a), 2'd3, "R5 second reset");
        check_lookup(25, 0, "R5 lookup after reset");

        repeat (3) @(negedge clk);
        check("R8 all reads answered", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule